// File: doc/BRIEF.md
# External Memory Bus Cycle Sequencer

This block generates the strobe pattern an 8-bit controller uses on its external memory bus. It runs from the oscillator clock and divides it into machine cycles of twelve periods, each split into two halves of six. In an ordinary instruction-fetch cycle, every half starts with an address latch enable pulse while the low program-counter byte sits on the multiplexed low bus. The low bus is then released and the active-low program store enable opens a three-period window for the returning instruction byte. The separate high bus carries the upper address byte throughout.

When the core raises a data-move request, the whole next machine cycle becomes a data access. It has a single address-latch pulse and no program store enable at all, so compared with two fetch halves one latch pulse and two program-store pulses are dropped. A six-period read or write strobe is placed in the middle of the cycle. The data address comes either from the 16-bit data pointer or from an 8-bit indirect address. In the 8-bit case the high bus shows the port-2 latch value. A control input suppresses the latch pulse in fetch cycles while keeping it in data cycles. A strap input routes fetches below the internal ROM size away from the external bus.

The core presents its request and addresses ahead of time. The block latches them at the edge that starts each machine cycle, and again at the mid-cycle edge for the second fetch address. Inputs may therefore change freely at other times.

Top module: `ebus_seq`

## Requirements
- R1: While reset is asserted, and in the cycle after reset is first sampled high, ale is 0, psen_n, rd_n and wr_n are 1, and ad_oe is 0, even when reset interrupts a strobe.
- R2: In a fetch cycle with ale_off=0, ale is high during phases 0-1 and 6-7 of the machine cycle, giving two 2-period pulses spaced 6 periods apart.
- R3: In an externally fetched half, psen_n is low for phases 3-5 of that half: it falls one period after ale falls and stays low for 3 periods.
- R4: In an externally fetched half, ad_oe is 1 and ad_out holds pc[7:0] during phases 0-2 of the half, and ad_oe is 0 during phases 3-5. a_hi shows pc[15:8] for the whole half. The pc value is taken at the edge that starts the half.
- R5: With int_rom_sel=1, a half whose fetch address is below 2000h (0000h-1FFFh) keeps psen_n at 1 and ad_oe at 0. An address of 2000h or above is always fetched externally. With int_rom_sel=0 every fetch is external.
- R6: A data cycle has exactly one ale pulse, in phases 0-1, and psen_n stays at 1 for all twelve phases.
- R7: In a read data cycle, rd_n is low for exactly phases 4-9 (6 periods), wr_n stays at 1, and ad_oe is 0 from phase 3 to phase 11.
- R8: In a write data cycle, wr_n is low for exactly phases 4-9, rd_n stays at 1, and ad_out carries wr_data with ad_oe=1 for phases 3-10, which is one period before the strobe falls and one period after it rises.
- R9: In a data cycle, ad_out shows the low address byte with ad_oe=1 during phases 0-2. With mv_wide=1 the address is dptr[7:0] on ad_out and dptr[15:8] on a_hi. With mv_wide=0 it is ind_addr on ad_out and p2_latch on a_hi.
- R10: A machine cycle that starts with ale_off=1 has no ale pulse if it is a fetch cycle, and still has its phase 0-1 pulse if it is a data cycle.
- R11: mc_start is 1 exactly in phase 0 of each machine cycle. Phase 0 of the first cycle begins at the first clock edge at which rst is sampled low. mv_req, mv_write, mv_wide, dptr, ind_addr, p2_latch, wr_data and ale_off are sampled only at the edge that ends phase 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock; one period is one phase |
| rst | input | 1 | Synchronous reset, active high |
| mv_req | input | 1 | Make the next machine cycle a data access |
| mv_write | input | 1 | Data access is a write (1) or a read (0) |
| mv_wide | input | 1 | Use the 16-bit data pointer (1) or the 8-bit indirect address (0) |
| pc | input | 16 | Program counter for the fetch half that is starting |
| dptr | input | 16 | Data pointer |
| ind_addr | input | 8 | 8-bit indirect data address |
| p2_latch | input | 8 | Port-2 latch value, shown on the high bus for 8-bit data addresses |
| wr_data | input | 8 | Byte to write |
| ale_off | input | 1 | Suppress the latch pulse in fetch cycles |
| int_rom_sel | input | 1 | Fetch the low program region internally |
| ale | output | 1 | Address latch enable |
| psen_n | output | 1 | Program store enable, active low |
| rd_n | output | 1 | Data read strobe, active low |
| wr_n | output | 1 | Data write strobe, active low |
| ad_out | output | 8 | Value driven on the multiplexed low bus |
| ad_oe | output | 1 | Low bus drive enable |
| a_hi | output | 8 | High address bus |
| mc_start | output | 1 | High in phase 0 of every machine cycle |

## Verification
Each scenario drives one machine cycle and compares every output in all twelve phases against a pattern built from the requirements. The cycles covered are fetches with two different program-counter values per half, fetches across the 1FFFh/2000h internal-ROM boundary, a read through the 16-bit pointer, and a write through the 8-bit indirect address. Because two differing fetch addresses are used, a sequencer that latches the address only once per cycle is caught. The read and write cycles separate the two address sources and the write-data window from the address window. Repeating a fetch and a write with the latch pulse disabled, running a read and a fetch back to back, and changing the request lines in the middle of a cycle show that context is captured only at cycle boundaries. A reset in the middle of a read strobe shows that the bus is released at once.

// File: rtl/ebus_pkg.sv
package ebus_pkg;

   // Kind of the machine cycle currently being sequenced
   typedef enum logic [1:0] {
      CYC_IDLE   = 2'd0,
      CYC_FETCH  = 2'd1,
      CYC_DREAD  = 2'd2,
      CYC_DWRITE = 2'd3
   } cyc_kind_e;

endpackage

// File: rtl/ebus_phase_gen.sv
module ebus_phase_gen #(
   parameter int MC_LEN   = 12,
   parameter int HALF_LEN = 6,
   parameter int PH_W     = 4
) (
   input  logic            clk,
   input  logic            rst,
   output logic [PH_W-1:0] ph,
   output logic            mc_last,
   output logic            half_last,
   output logic            mc_start
);

   localparam logic [PH_W-1:0] LAST_P = PH_W'(MC_LEN - 1);
   localparam logic [PH_W-1:0] HALF_P = PH_W'(HALF_LEN - 1);

   // Reset parks the counter on the last phase so that the first edge
   // after reset opens phase 0 of a fresh machine cycle.
   always_ff @(posedge clk) begin
      if (rst) begin
         ph <= LAST_P;
      end else if (ph == LAST_P) begin
         ph <= '0;
      end else begin
         ph <= ph + 1'b1;
      end
   end

   assign mc_last   = (ph == LAST_P);
   assign half_last = (ph == HALF_P);
   assign mc_start  = (ph == '0);

endmodule

// File: rtl/ebus_cycle_ctx.sv
module ebus_cycle_ctx
   import ebus_pkg::*;
#(
   parameter int ADDR_W        = 16,
   parameter int DATA_W        = 8,
   parameter int HI_W          = 8,
   parameter int INT_ROM_BYTES = 8192
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              mc_last,
   input  logic              half_last,
   input  logic              mv_req,
   input  logic              mv_write,
   input  logic              mv_wide,
   input  logic [ADDR_W-1:0] pc,
   input  logic [ADDR_W-1:0] dptr,
   input  logic [DATA_W-1:0] ind_addr,
   input  logic [HI_W-1:0]   p2_latch,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              ale_off,
   input  logic              int_rom_sel,
   output cyc_kind_e         kind,
   output logic              ale_quiet,
   output logic [DATA_W-1:0] lo_addr,
   output logic [HI_W-1:0]   hi_addr,
   output logic [DATA_W-1:0] wdat,
   output logic              fetch_ext
);

   logic go_ext;

   // The ROM size picks the routing variant: no internal ROM means every
   // fetch leaves the chip, otherwise the low region can stay inside.
   generate
      if (INT_ROM_BYTES == 0) begin : g_no_rom
         assign go_ext = 1'b1;
      end else begin : g_rom
         localparam logic [ADDR_W:0] ROM_LIM = (ADDR_W + 1)'(INT_ROM_BYTES);
         assign go_ext = !int_rom_sel || ({1'b0, pc} >= ROM_LIM);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         kind      <= CYC_IDLE;
         ale_quiet <= 1'b0;
         lo_addr   <= '0;
         hi_addr   <= '0;
         wdat      <= '0;
         fetch_ext <= 1'b0;
      end else if (mc_last) begin
         ale_quiet <= ale_off;
         if (mv_req) begin
            kind      <= mv_write ? CYC_DWRITE : CYC_DREAD;
            lo_addr   <= mv_wide ? dptr[DATA_W-1:0] : ind_addr;
            hi_addr   <= mv_wide ? dptr[ADDR_W-1:DATA_W] : p2_latch;
            wdat      <= wr_data;
            fetch_ext <= 1'b0;
         end else begin
            kind      <= CYC_FETCH;
            lo_addr   <= pc[DATA_W-1:0];
            hi_addr   <= pc[ADDR_W-1:DATA_W];
            fetch_ext <= go_ext;
         end
      end else if (half_last && (kind == CYC_FETCH)) begin
         // second fetch half takes a fresh program counter
         lo_addr   <= pc[DATA_W-1:0];
         hi_addr   <= pc[ADDR_W-1:DATA_W];
         fetch_ext <= go_ext;
      end
   end

endmodule

// File: rtl/ebus_strobe_dec.sv
module ebus_strobe_dec
   import ebus_pkg::*;
#(
   parameter int DATA_W   = 8,
   parameter int HI_W     = 8,
   parameter int PH_W     = 4,
   parameter int ALE_LEN  = 2,
   parameter int PSEN_LEN = 3,
   parameter int STB_LEN  = 6
) (
   input  logic [PH_W-1:0]   ph,
   input  cyc_kind_e         kind,
   input  logic              ale_quiet,
   input  logic [DATA_W-1:0] lo_addr,
   input  logic [HI_W-1:0]   hi_addr,
   input  logic [DATA_W-1:0] wdat,
   input  logic              fetch_ext,
   output logic              ale,
   output logic              psen_n,
   output logic              rd_n,
   output logic              wr_n,
   output logic [DATA_W-1:0] ad_out,
   output logic              ad_oe,
   output logic [HI_W-1:0]   a_hi
);

   localparam int HALF_LEN = ALE_LEN + 1 + PSEN_LEN;

   // Phase landmarks, all derived from the pulse lengths
   localparam logic [PH_W-1:0] HALF_P     = PH_W'(HALF_LEN);
   localparam logic [PH_W-1:0] ALE_P      = PH_W'(ALE_LEN);
   localparam logic [PH_W-1:0] HOLD_P     = PH_W'(ALE_LEN);
   localparam logic [PH_W-1:0] PSEN_P     = PH_W'(ALE_LEN + 1);
   localparam logic [PH_W-1:0] STB_FROM_P = PH_W'(ALE_LEN + 2);
   localparam logic [PH_W-1:0] STB_TO_P   = PH_W'(ALE_LEN + 1 + STB_LEN);
   localparam logic [PH_W-1:0] WD_TO_P    = PH_W'(ALE_LEN + 2 + STB_LEN);

   logic [PH_W-1:0] sub;
   logic            strobe;

   always_comb begin
      sub    = (ph >= HALF_P) ? (ph - HALF_P) : ph;
      strobe = 1'b0;
      ale    = 1'b0;
      psen_n = 1'b1;
      rd_n   = 1'b1;
      wr_n   = 1'b1;
      ad_oe  = 1'b0;
      ad_out = lo_addr;
      a_hi   = hi_addr;
      unique case (kind)
         CYC_FETCH: begin
            ale = !ale_quiet && (sub < ALE_P);
            if (fetch_ext) begin
               psen_n = !(sub >= PSEN_P);
               ad_oe  = (sub <= HOLD_P);
            end
         end
         CYC_DREAD, CYC_DWRITE: begin
            ale    = (ph < ALE_P);
            strobe = (ph >= STB_FROM_P) && (ph <= STB_TO_P);
            if (ph <= HOLD_P) begin
               ad_oe = 1'b1;
            end else if ((kind == CYC_DWRITE) && (ph <= WD_TO_P)) begin
               ad_oe  = 1'b1;
               ad_out = wdat;
            end
            rd_n = !(strobe && (kind == CYC_DREAD));
            wr_n = !(strobe && (kind == CYC_DWRITE));
         end
         default: begin
         end
      endcase
   end

endmodule

// File: rtl/ebus_seq.sv
module ebus_seq
   import ebus_pkg::*;
#(
   parameter int ADDR_W        = 16,
   parameter int DATA_W        = 8,
   parameter int ALE_LEN       = 2,
   parameter int PSEN_LEN      = 3,
   parameter int STB_LEN       = 6,
   parameter int INT_ROM_BYTES = 8192
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     mv_req,
   input  logic                     mv_write,
   input  logic                     mv_wide,
   input  logic [ADDR_W-1:0]        pc,
   input  logic [ADDR_W-1:0]        dptr,
   input  logic [DATA_W-1:0]        ind_addr,
   input  logic [ADDR_W-DATA_W-1:0] p2_latch,
   input  logic [DATA_W-1:0]        wr_data,
   input  logic                     ale_off,
   input  logic                     int_rom_sel,
   output logic                     ale,
   output logic                     psen_n,
   output logic                     rd_n,
   output logic                     wr_n,
   output logic [DATA_W-1:0]        ad_out,
   output logic                     ad_oe,
   output logic [ADDR_W-DATA_W-1:0] a_hi,
   output logic                     mc_start
);

   localparam int HI_W     = ADDR_W - DATA_W;
   localparam int HALF_LEN = ALE_LEN + 1 + PSEN_LEN;
   localparam int MC_LEN   = 2 * HALF_LEN;
   localparam int PH_W     = $clog2(MC_LEN);

   // Elaboration-time parameter checks
   generate
      if (ALE_LEN < 1 || PSEN_LEN < 1 || STB_LEN < 1) begin : g_bad_len
         $error("ebus_seq: pulse lengths must be at least one period");
      end
      if (ADDR_W <= DATA_W) begin : g_bad_width
         $error("ebus_seq: address must be wider than the data bus");
      end
      if (ALE_LEN + 2 + STB_LEN > MC_LEN - 1) begin : g_bad_strobe
         $error("ebus_seq: data strobe does not fit into one machine cycle");
      end
      if (INT_ROM_BYTES < 0 || INT_ROM_BYTES > (2 ** ADDR_W)) begin : g_bad_rom
         $error("ebus_seq: internal ROM size exceeds the address space");
      end
   endgenerate

   logic [PH_W-1:0]   ph;
   logic              mc_last;
   logic              half_last;
   cyc_kind_e         kind;
   logic              ale_quiet;
   logic [DATA_W-1:0] lo_addr;
   logic [HI_W-1:0]   hi_addr;
   logic [DATA_W-1:0] wdat;
   logic              fetch_ext;

   ebus_phase_gen #(
      .MC_LEN   (MC_LEN),
      .HALF_LEN (HALF_LEN),
      .PH_W     (PH_W)
   ) u_phase (
      .clk       (clk),
      .rst       (rst),
      .ph        (ph),
      .mc_last   (mc_last),
      .half_last (half_last),
      .mc_start  (mc_start)
   );

   ebus_cycle_ctx #(
      .ADDR_W        (ADDR_W),
      .DATA_W        (DATA_W),
      .HI_W          (HI_W),
      .INT_ROM_BYTES (INT_ROM_BYTES)
   ) u_ctx (
      .clk         (clk),
      .rst         (rst),
      .mc_last     (mc_last),
      .half_last   (half_last),
      .mv_req      (mv_req),
      .mv_write    (mv_write),
      .mv_wide     (mv_wide),
      .pc          (pc),
      .dptr        (dptr),
      .ind_addr    (ind_addr),
      .p2_latch    (p2_latch),
      .wr_data     (wr_data),
      .ale_off     (ale_off),
      .int_rom_sel (int_rom_sel),
      .kind        (kind),
      .ale_quiet   (ale_quiet),
      .lo_addr     (lo_addr),
      .hi_addr     (hi_addr),
      .wdat        (wdat),
      .fetch_ext   (fetch_ext)
   );

   ebus_strobe_dec #(
      .DATA_W   (DATA_W),
      .HI_W     (HI_W),
      .PH_W     (PH_W),
      .ALE_LEN  (ALE_LEN),
      .PSEN_LEN (PSEN_LEN),
      .STB_LEN  (STB_LEN)
   ) u_dec (
      .ph        (ph),
      .kind      (kind),
      .ale_quiet (ale_quiet),
      .lo_addr   (lo_addr),
      .hi_addr   (hi_addr),
      .wdat      (wdat),
      .fetch_ext (fetch_ext),
      .ale       (ale),
      .psen_n    (psen_n),
      .rd_n      (rd_n),
      .wr_n      (wr_n),
      .ad_out    (ad_out),
      .ad_oe     (ad_oe),
      .a_hi      (a_hi)
   );

endmodule

// File: rtl/ebus_seq_chk.sv
module ebus_seq_chk #(
   parameter int ALE_LEN = 2,
   parameter int STB_LEN = 6,
   parameter int MC_LEN  = 12
) (
   input logic clk,
   input logic rst,
   input logic ale,
   input logic psen_n,
   input logic rd_n,
   input logic wr_n,
   input logic ad_oe,
   input logic mc_start
);

   logic        was_rst;
   logic        seen_start;
   logic [15:0] ale_run;
   logic [15:0] stb_run;
   logic [15:0] since_start;

   always_ff @(posedge clk) begin
      was_rst <= rst;
      if (rst) begin
         ale_run     <= '0;
         stb_run     <= '0;
         since_start <= '0;
         seen_start  <= 1'b0;
      end else begin
         ale_run <= ale ? ale_run + 16'd1 : 16'd0;
         stb_run <= (!rd_n || !wr_n) ? stb_run + 16'd1 : 16'd0;
         if (mc_start) begin
            since_start <= '0;
            seen_start  <= 1'b1;
         end else begin
            since_start <= since_start + 16'd1;
         end
      end
   end

   // R1: the edge after reset is sampled high shows a quiet bus
   a_r1_reset_quiet: assert property (@(posedge clk)
      was_rst |-> (!ale && psen_n && rd_n && wr_n && !ad_oe));

   // R2: every latch pulse lasts ALE_LEN periods
   a_r2_ale_width: assert property (@(posedge clk) disable iff (rst)
      (!was_rst && $fell(ale)) |-> (ale_run == 16'(ALE_LEN)));

   // R3: program store and latch pulse never overlap
   a_r3_psen_not_with_ale: assert property (@(posedge clk) disable iff (rst)
      !psen_n |-> !ale);

   // R6: no program store activity during a data strobe
   a_r6_no_psen_in_strobe: assert property (@(posedge clk) disable iff (rst)
      (!rd_n || !wr_n) |-> psen_n);

   // R7: read strobe has the bus released
   a_r7_read_released: assert property (@(posedge clk) disable iff (rst)
      !rd_n |-> !ad_oe);

   // R7: a completed data strobe lasts STB_LEN periods
   a_r7_strobe_len: assert property (@(posedge clk) disable iff (rst)
      (!was_rst && $rose(rd_n && wr_n)) |-> (stb_run == 16'(STB_LEN)));

   // R8: write strobe has the bus driven
   a_r8_write_driven: assert property (@(posedge clk) disable iff (rst)
      !wr_n |-> ad_oe);

   // R11: machine cycle start repeats every MC_LEN periods
   a_r11_mc_period: assert property (@(posedge clk) disable iff (rst)
      (mc_start && seen_start) |-> (since_start == 16'(MC_LEN - 1)));

endmodule

bind ebus_seq ebus_seq_chk #(
   .ALE_LEN (ALE_LEN),
   .STB_LEN (STB_LEN),
   .MC_LEN  (MC_LEN)
) u_chk (
   .clk      (clk),
   .rst      (rst),
   .ale      (ale),
   .psen_n   (psen_n),
   .rd_n     (rd_n),
   .wr_n     (wr_n),
   .ad_oe    (ad_oe),
   .mc_start (mc_start)
);

// File: tb/ebus_seq_bench.sv
module ebus_seq_bench;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        mv_req = 1'b0;
   logic        mv_write = 1'b0;
   logic        mv_wide = 1'b0;
   logic [15:0] pc = '0;
   logic [15:0] dptr = '0;
   logic [7:0]  ind_addr = '0;
   logic [7:0]  p2_latch = '0;
   logic [7:0]  wr_data = '0;
   logic        ale_off = 1'b0;
   logic        int_rom_sel = 1'b0;
   logic        ale;
   logic        psen_n;
   logic        rd_n;
   logic        wr_n;
   logic [7:0]  ad_out;
   logic        ad_oe;
   logic [7:0]  a_hi;
   logic        mc_start;

   int n_chk = 0;
   int n_bad = 0;
   logic [3:0] bph;

   always #4 clk = ~clk;

   ebus_seq u_ebus_seq (
      .clk (clk), .rst (rst), .mv_req (mv_req), .mv_write (mv_write),
      .mv_wide (mv_wide), .pc (pc), .dptr (dptr), .ind_addr (ind_addr),
      .p2_latch (p2_latch), .wr_data (wr_data), .ale_off (ale_off),
      .int_rom_sel (int_rom_sel), .ale (ale), .psen_n (psen_n),
      .rd_n (rd_n), .wr_n (wr_n), .ad_out (ad_out), .ad_oe (ad_oe),
      .a_hi (a_hi), .mc_start (mc_start)
   );

   // Bench phase reference, per R11: phase 0 at the first edge with rst low
   always @(posedge clk) begin
      if (rst) bph <= 4'd11;
      else     bph <= (bph == 4'd11) ? 4'd0 : bph + 4'd1;
   end

   task automatic chk(input string req, input string what,
                      input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic chk_quiet(input string what);
      chk("R1", {what, " ale"},    16'(ale),    16'd0);
      chk("R1", {what, " psen_n"}, 16'(psen_n), 16'd1);
      chk("R1", {what, " rd_n"},   16'(rd_n),   16'd1);
      chk("R1", {what, " wr_n"},   16'(wr_n),   16'd1);
      chk("R1", {what, " ad_oe"},  16'(ad_oe),  16'd0);
   endtask

   task automatic wait_last_phase();
      @(negedge clk);
      while (bph != 4'd11) @(negedge clk);
   endtask

   // One machine cycle: kind 0 fetch, 1 read, 2 write
   task automatic run_mc(input string name, input int kind, input logic wide,
                         input logic [15:0] pc0, input logic [15:0] pc1,
                         input logic [15:0] dp, input logic [7:0] ind,
                         input logic [7:0] p2, input logic [7:0] wd,
                         input logic aoff, input logic romsel);
      wait_last_phase();
      mv_req = (kind != 0); mv_write = (kind == 2); mv_wide = wide;
      pc = pc0; dptr = dp; ind_addr = ind; p2_latch = p2; wr_data = wd;
      ale_off = aoff; int_rom_sel = romsel;
      for (int p = 0; p < 12; p++) begin
         logic [15:0] pch;
         logic        ext, e_ale, e_psen, e_rd, e_wr, e_oe;
         logic [7:0]  e_out, e_hi;
         string       t_ale, t_psen, t_bus, t_hi;
         int          s;
         @(negedge clk);
         s   = p % 6;
         pch = (p < 6) ? pc0 : pc1;
         e_rd = 1'b1; e_wr = 1'b1;
         if (kind == 0) begin
            ext    = !romsel || (pch >= 16'h2000);
            e_ale  = !aoff && (s < 2);
            e_psen = !(ext && s >= 3);
            e_oe   = ext && (s <= 2);
            e_out  = pch[7:0];
            e_hi   = pch[15:8];
            t_ale  = aoff ? "R10" : "R2";
            t_psen = romsel ? "R5" : "R3";
            t_bus  = romsel ? "R5" : "R4";
            t_hi   = "R4";
         end else begin
            e_ale  = (p < 2);
            e_psen = 1'b1;
            e_rd   = !(kind == 1 && p >= 4 && p <= 9);
            e_wr   = !(kind == 2 && p >= 4 && p <= 9);
            e_oe   = (p <= 2) || (kind == 2 && p <= 10);
            e_out  = (p <= 2) ? (wide ? dp[7:0] : ind) : wd;
            e_hi   = wide ? dp[15:8] : p2;
            t_ale  = aoff ? "R10" : "R6";
            t_psen = "R6";
            t_bus  = (p <= 2) ? "R9" : ((kind == 2) ? "R8" : "R7");
            t_hi   = "R9";
         end
         chk(t_ale,  $sformatf("%s ph%0d ale", name, p),    16'(ale),    16'(e_ale));
         chk(t_psen, $sformatf("%s ph%0d psen_n", name, p), 16'(psen_n), 16'(e_psen));
         chk("R7",   $sformatf("%s ph%0d rd_n", name, p),   16'(rd_n),   16'(e_rd));
         chk("R8",   $sformatf("%s ph%0d wr_n", name, p),   16'(wr_n),   16'(e_wr));
         chk(t_bus,  $sformatf("%s ph%0d ad_oe", name, p),  16'(ad_oe),  16'(e_oe));
         if (e_oe)
            chk(t_bus, $sformatf("%s ph%0d ad_out", name, p), 16'(ad_out), 16'(e_out));
         chk(t_hi,  $sformatf("%s ph%0d a_hi", name, p),     16'(a_hi),     16'(e_hi));
         chk("R11", $sformatf("%s ph%0d mc_start", name, p), 16'(mc_start), 16'(p == 0));
         // R11: disturb sampled inputs mid-cycle; only the phase-11 edge counts
         if (p == 0) begin
            mv_req = (kind == 0); mv_write = !mv_write; mv_wide = !mv_wide;
            dptr = ~dp; ind_addr = ~ind; p2_latch = ~p2; wr_data = ~wd;
            ale_off = !aoff;
         end
         if (p == 5) pc = pc1;
         if (p == 10) begin
            mv_req = 1'b0; ale_off = 1'b0;
         end
      end
   endtask

   task automatic t_reset_start();
      rst = 1'b1;
      repeat (2) @(negedge clk);
      chk_quiet("reset hold");
      rst = 1'b0;
   endtask

   task automatic t_reset_mid_read();
      wait_last_phase();
      mv_req = 1'b1; mv_write = 1'b0; mv_wide = 1'b1; dptr = 16'h4321;
      @(negedge clk);
      while (bph != 4'd5) @(negedge clk);
      chk("R7", "pre-reset rd_n low", 16'(rd_n), 16'd0);
      mv_req = 1'b0;
      rst = 1'b1;
      @(negedge clk);
      chk_quiet("reset mid strobe");
      rst = 1'b0;
   endtask

   initial begin
      #(8 * 200000);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      t_reset_start();
      run_mc("fetch_ext",   0, 1'b0, 16'h1234, 16'h1235, 16'h0, 8'h0, 8'h0, 8'h0, 1'b0, 1'b0);
      run_mc("fetch_a5",    0, 1'b0, 16'hA55A, 16'h5AA5, 16'h0, 8'h0, 8'h0, 8'h0, 1'b0, 1'b0);
      run_mc("fetch_rom",   0, 1'b0, 16'h1FFF, 16'h2000, 16'h0, 8'h0, 8'h0, 8'h0, 1'b0, 1'b1);
      run_mc("fetch_rom0",  0, 1'b0, 16'h0000, 16'hFFFF, 16'h0, 8'h0, 8'h0, 8'h0, 1'b0, 1'b1);
      run_mc("read_wide",   1, 1'b1, 16'h0, 16'h0, 16'hA55A, 8'h11, 8'h22, 8'h00, 1'b0, 1'b0);
      run_mc("fetch_after", 0, 1'b0, 16'h3000, 16'h3001, 16'h0, 8'h0, 8'h0, 8'h0, 1'b0, 1'b0);
      run_mc("write_narrow",2, 1'b0, 16'h0, 16'h0, 16'hBEEF, 8'h3C, 8'hC3, 8'h96, 1'b0, 1'b0);
      run_mc("read_narrow", 1, 1'b0, 16'h0, 16'h0, 16'h7777, 8'h81, 8'h7E, 8'h00, 1'b0, 1'b0);
      run_mc("write_wide",  2, 1'b1, 16'h0, 16'h0, 16'h1F2E, 8'h00, 8'h00, 8'h5A, 1'b0, 1'b0);
      run_mc("fetch_aleoff",0, 1'b0, 16'h4444, 16'h4445, 16'h0, 8'h0, 8'h0, 8'h0, 1'b1, 1'b0);
      run_mc("write_aleoff",2, 1'b0, 16'h0, 16'h0, 16'h0, 8'h55, 8'hAA, 8'hF0, 1'b1, 1'b0);
      t_reset_mid_read();
      run_mc("fetch_post",  0, 1'b0, 16'h0102, 16'h0304, 16'h0, 8'h0, 8'h0, 8'h0, 1'b0, 1'b0);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule